// File: doc/BRIEF.md
# Vector Lane Start-Offset Shuffle Unit

This block gathers eight 32-bit words out of a wide source buffer and presents them as one eight-lane vector. A single start index is shared by every lane. Each lane also has its own 4-bit step, and all eight steps are packed into one 32-bit control word. A lane reads the source word at the start index plus its own step. The words are moved as opaque bit patterns and are not interpreted as numbers, so real data and interleaved real/imaginary data pass through alike.

The source buffer is 32 words deep. A depth control can make it act as a 16-word buffer. In either depth the index sum wraps around the active depth, so a lane can never select a word outside the buffer. The gathered vector is captured in a register, and a valid strobe follows the input strobe one cycle later. Two copies of the block, one per operand, are meant to sit in front of a lane-wise multiplier stage.

Top module: `lane_gather`

## Requirements
- R1: Lane i reads source word (start_idx + lane_offsets[4i+3:4i]). Lane 0 uses the least significant nibble. Source word k occupies src_words[32k+31:32k], and lane i is driven on lanes_out[32i+31:32i]. Example: start 2 with control word 0x210FEDCB selects words 0xD, 0xE, 0xF, 0x10, 0x11, 0x2, 0x3, 0x4 for lanes 0 to 7.
- R2: With half_depth = 0 the index sum wraps modulo 32. For example, start 31 with step 15 selects word 14.
- R3: With half_depth = 1 the index sum wraps modulo 16, and source words 16 to 31 have no effect on the output.
- R4: A vector presented with in_valid = 1 at a rising edge appears on lanes_out after that edge and not before it. out_valid equals in_valid delayed by one cycle.
- R5: While in_valid = 0, lanes_out holds its last value whatever the other inputs do.
- R6: While rst_n = 0, out_valid is 0 and lanes_out is all zeros.
- R7: Words are copied bit for bit, including NaN, negative-zero and all-ones patterns.
- R8: Lanes whose steps are equal receive the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Capture strobe for the current inputs |
| half_depth | input | 1 | 1: 16-word buffer, 0: 32-word buffer |
| start_idx | input | 5 | Start index shared by all lanes |
| lane_offsets | input | 32 | Packed 4-bit step per lane, lane 0 in bits 3:0 |
| src_words | input | 1024 | Source buffer of 32 words, word k in bits 32k+31:32k |
| out_valid | output | 1 | in_valid delayed by one cycle |
| lanes_out | output | 256 | Gathered vector, lane i in bits 32i+31:32i |

## Verification
The bench builds the block with its default parameters: 32-bit words, eight lanes, a 32-word buffer and 4-bit steps. With a 5-bit start index and a 4-bit step, the index sum reaches 46. This exercises wrap-around in both depths, including the case where a sum from the lower half of the buffer spills past word 15 in the 16-word setting. Word values are random, so a wrong lane, a wrong nibble or a wrong modulus shows up as a mismatched word.

// File: rtl/lane_gather.sv
module lane_gather #(
  parameter int WORD_W = 32,
  parameter int LANES  = 8,
  parameter int DEPTH  = 32,
  parameter int STEP_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      half_depth,
  input  logic [$clog2(DEPTH)-1:0]  start_idx,
  input  logic [LANES*STEP_W-1:0]   lane_offsets,
  input  logic [DEPTH*WORD_W-1:0]   src_words,
  output logic                      out_valid,
  output logic [LANES*WORD_W-1:0]   lanes_out
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] HALF_MASK = IDX_W'(DEPTH/2 - 1);

  logic [WORD_W-1:0] words [DEPTH];
  logic [LANES*WORD_W-1:0] picked;

  for (genvar k = 0; k < DEPTH; k++) begin : g_word
    assign words[k] = src_words[k*WORD_W +: WORD_W];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [IDX_W-1:0] sum, idx;
    assign sum = start_idx + IDX_W'(lane_offsets[i*STEP_W +: STEP_W]);
    assign idx = half_depth ? (sum & HALF_MASK) : sum;
    assign picked[i*WORD_W +: WORD_W] = words[idx];

    // R8: equal steps give equal words
    assert_equal_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) &&
       $past(lane_offsets[i*STEP_W +: STEP_W]) == $past(lane_offsets[STEP_W-1:0]))
      |-> lanes_out[i*WORD_W +: WORD_W] == lanes_out[WORD_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      lanes_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) lanes_out <= picked;
    end
  end

  assert_valid_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> $stable(lanes_out));

  assert_reset_clear_R6: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && lanes_out == '0));

endmodule

// File: tb/lane_gather_tb_top.sv
`timescale 1ns/1ps
module lane_gather_tb_top;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          half_depth = 1'b0;
  logic [4:0]    start_idx = '0;
  logic [31:0]   lane_offsets = '0;
  logic [1023:0] src_words = '0;
  logic          out_valid;
  logic [255:0]  lanes_out;

  int checks = 0;
  int failures = 0;
  logic [31:0]  mem [32];
  logic [255:0] last_exp = '0;

  always #2.5 clk = ~clk;

  lane_gather dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .half_depth(half_depth),
    .start_idx(start_idx), .lane_offsets(lane_offsets), .src_words(src_words),
    .out_valid(out_valid), .lanes_out(lanes_out)
  );

  function automatic logic [1023:0] pack_mem();
    logic [1023:0] b;
    for (int k = 0; k < 32; k++) b[32*k +: 32] = mem[k];
    return b;
  endfunction

  function automatic logic [255:0] model(input logic h, input logic [4:0] s, input logic [31:0] o);
    logic [255:0] v;
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = int'(s) + int'((o >> (4*i)) & 32'hF);
      idx = h ? idx % 16 : idx % 32;
      v[32*i +: 32] = mem[idx];
    end
    return v;
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_pattern(input logic [31:0] base);
    for (int k = 0; k < 32; k++) mem[k] = base + 32'(k);
  endtask

  task automatic fill_random();
    for (int k = 0; k < 32; k++) mem[k] = $urandom;
  endtask

  task automatic issue(input logic h, input logic [4:0] s, input logic [31:0] o, input string req);
    @(negedge clk);
    in_valid = 1'b1; half_depth = h; start_idx = s; lane_offsets = o;
    src_words = pack_mem();
    last_exp = model(h, s, o);
    @(posedge clk); #1;
    chk(req, lanes_out, last_exp);
    chk("R4", {255'd0, out_valid}, 256'd1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1;
    chk("R6", {255'd0, out_valid}, 256'd0);
    chk("R6", lanes_out, 256'd0);
    @(negedge clk); rst_n = 1'b1;

    fill_pattern(32'hA000_0000);
    issue(1'b0, 5'd2, 32'h210FEDCB, "R1");
    issue(1'b0, 5'd7, 32'h76543210, "R1");
    @(posedge clk); #1;
    chk("R4", {255'd0, out_valid}, 256'd0);

    issue(1'b0, 5'd31, 32'hFFFFFFFF, "R2");
    issue(1'b0, 5'd20, 32'hFEDCBA98, "R2");

    issue(1'b1, 5'd10, 32'h76543210, "R3");
    begin
      logic [255:0] first;
      first = last_exp;
      for (int k = 16; k < 32; k++) mem[k] = ~mem[k];
      issue(1'b1, 5'd10, 32'h76543210, "R3");
      chk("R3", lanes_out, first);
    end
    issue(1'b1, 5'd31, 32'hF0F0F0F0, "R3");

    fill_pattern(32'h0000_1000);
    @(negedge clk);
    start_idx = 5'd3; lane_offsets = 32'h12345678; src_words = ~pack_mem();
    #1;
    chk("R4", lanes_out, last_exp);
    repeat (4) @(posedge clk);
    #1;
    chk("R5", lanes_out, last_exp);
    chk("R5", {255'd0, out_valid}, 256'd0);

    fill_random();
    issue(1'b0, 5'd9, 32'h55555555, "R8");
    for (int i = 1; i < 8; i++) chk("R8", {224'd0, lanes_out[32*i +: 32]}, {224'd0, lanes_out[31:0]});

    mem[0] = 32'h7FC0_0001; mem[1] = 32'h8000_0000; mem[2] = 32'hFFFF_FFFF; mem[3] = 32'h0000_0000;
    issue(1'b0, 5'd0, 32'h32103210, "R7");

    for (int n = 0; n < 300; n++) begin
      logic h;
      fill_random();
      h = 1'($urandom_range(0, 1));
      issue(h, 5'($urandom_range(0, 31)), $urandom, h ? "R3" : "R1");
    end

    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R6", lanes_out, 256'd0);
    chk("R6", {255'd0, out_valid}, 256'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule